// File: doc/BRIEF.md
# Two-Level Address Routing Decoder

This block turns a request address into a destination for an interconnect built in two tiers: clusters at the top, and target ports inside each cluster. The top address subfield indexes a global table that names the cluster. The next subfield indexes that cluster's own local table, which names the target port. Each cluster has its own local table, so two clusters can map the same local subfield to different ports. Both tables are loaded at run time through a small write port. Every entry carries a valid bit, and an address that reaches an invalid entry produces a decode error instead of a destination.

On the response side, the source identifier carried by a response is split into a cluster field and an initiator field. A cluster field that names a cluster beyond the configured count is flagged. For each request the block also reports cacheability. The address is ANDed with a shared mask and compared against up to four programmable patterns, and the flag is the OR of all enabled matches. All decoded outputs are registered and appear one clock after the valid input is sampled.

Top module: `route_decoder`

## Requirements
- R1: After reset is released, cmd_valid_o, cmd_err_o, cmd_cache_o, rsp_valid_o and rsp_err_o are low, and every table entry and pattern enable is cleared, so any request decodes to an error.
- R2: For a request, the global subfield addr[31:24] indexes the global table, and cmd_cluster_o shows the stored cluster number in the cycle after req_valid_i is sampled.
- R3: The local subfield addr[23:20] indexes the local table of the cluster chosen by the global lookup, and cmd_target_o shows the stored target. Different clusters keep independent local contents.
- R4: When either the global entry or the local entry is invalid, cmd_err_o is high for exactly one cycle, cmd_valid_o stays low, and cmd_cluster_o and cmd_target_o read 0.
- R5: cmd_valid_o, cmd_err_o and cmd_cache_o are high only in the cycle after a sampled req_valid_i. For each sampled request, exactly one of cmd_valid_o and cmd_err_o is high.
- R6: cmd_cache_o is high when, for some enabled pattern slot p, (addr AND mask) equals pattern[p].
- R7: For a sampled rsp_valid_i, the next cycle shows rsp_valid_o=1, rsp_cluster_o=srcid[9:2] and rsp_initiator_o=srcid[1:0]. rsp_err_o=1 when srcid[9:2] is greater than or equal to NUM_CLUSTERS. All response outputs read 0 when no response was sampled.
- R8: Table writes use cfg_we_i, cfg_sel_i, cfg_idx_i and cfg_data_i. With sel 0 (global), idx[7:0] is the subfield, data[32] is valid and data[1:0] is the cluster. With sel 1 (local), idx[5:4] is the cluster, idx[3:0] is the subfield, data[32] is valid and data[3:0] is the target. With sel 2, data[31:0] is the mask. With sel 3, idx[1:0] is the slot, data[31:0] is the pattern and data[32] is the enable.
- R9: A table write in the same cycle as a request does not affect that request, which decodes with the old contents. The next request sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request address valid |
| req_addr_i | input | ADDR_W | Request address |
| cmd_valid_o | output | 1 | Decoded destination valid |
| cmd_cluster_o | output | CLU_W | Destination cluster |
| cmd_target_o | output | TGT_W | Target port within cluster |
| cmd_err_o | output | 1 | Decode error (invalid entry) |
| cmd_cache_o | output | 1 | Address is cacheable |
| rsp_valid_i | input | 1 | Response identifier valid |
| rsp_srcid_i | input | SRC_W | Response source identifier |
| rsp_valid_o | output | 1 | Decoded response valid |
| rsp_cluster_o | output | SRC_GLB_W | Response cluster field |
| rsp_initiator_o | output | SRC_W-SRC_GLB_W | Response initiator field |
| rsp_err_o | output | 1 | Response cluster out of range |
| cfg_we_i | input | 1 | Table write enable |
| cfg_sel_i | input | 2 | Write target select |
| cfg_idx_i | input | CFG_IDX_W | Write index |
| cfg_data_i | input | ADDR_W+1 | Write data, top bit is valid/enable |

## Verification
A corrupted global or local entry appears one cycle after the next request that indexes it, either as a wrong cluster or target or as a spurious error. This is why the bench programs two clusters with different local contents and uses one local subfield in both. A stale pattern, enable or mask shows up on cmd_cache_o in that same cycle, so match, miss and disabled-slot cases are all checked. A write that takes effect too early is exposed by issuing a request in the same cycle as the write that invalidates its entry.

// File: rtl/route_pkg.sv
package route_pkg;
  typedef enum logic [1:0] {
    CFG_GLOBAL  = 2'd0,
    CFG_LOCAL   = 2'd1,
    CFG_MASK    = 2'd2,
    CFG_PATTERN = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/rt_global_table.sv
module rt_global_table #(
  parameter int IDX_W = 8,
  parameter int CLU_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic             wvalid_i,
  input  logic [CLU_W-1:0] wclu_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic             rvalid_o,
  output logic [CLU_W-1:0] rclu_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] valid_q;
  logic [CLU_W-1:0] clu_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (we_i) begin
      valid_q[widx_i] <= wvalid_i;
    end
  end

  // payload needs no reset: qualified by valid_q
  always_ff @(posedge clk_i) begin
    if (we_i) clu_q[widx_i] <= wclu_i;
  end

  assign rvalid_o = valid_q[ridx_i];
  assign rclu_o   = clu_q[ridx_i];

  AST_GLB_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (valid_q[$past(widx_i)] == $past(wvalid_i))); // R8
endmodule

// File: rtl/rt_local_tables.sv
module rt_local_tables #(
  parameter int NUM_CLUSTERS = 4,
  parameter int CLU_W        = 2,
  parameter int LOC_W        = 4,
  parameter int TGT_W        = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CLU_W-1:0] wclu_i,
  input  logic [LOC_W-1:0] wloc_i,
  input  logic             wvalid_i,
  input  logic [TGT_W-1:0] wtgt_i,
  input  logic [CLU_W-1:0] rclu_i,
  input  logic [LOC_W-1:0] rloc_i,
  output logic             rvalid_o,
  output logic [TGT_W-1:0] rtgt_o
);
  localparam int DEPTH = 1 << LOC_W;

  logic [NUM_CLUSTERS-1:0] clu_we;
  logic [NUM_CLUSTERS-1:0] clu_rvalid;
  logic [TGT_W-1:0]        clu_rtgt [NUM_CLUSTERS];

  for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_clu
    logic [DEPTH-1:0] valid_q;
    logic [TGT_W-1:0] tgt_q [DEPTH];

    assign clu_we[c] = we_i && (int'(wclu_i) == c);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= '0;
      end else if (clu_we[c]) begin
        valid_q[wloc_i] <= wvalid_i;
      end
    end

    always_ff @(posedge clk_i) begin
      if (clu_we[c]) tgt_q[wloc_i] <= wtgt_i;
    end

    assign clu_rvalid[c] = valid_q[rloc_i];
    assign clu_rtgt[c]   = tgt_q[rloc_i];
  end

  always_comb begin
    rvalid_o = 1'b0;
    rtgt_o   = '0;
    if (int'(rclu_i) < NUM_CLUSTERS) begin
      rvalid_o = clu_rvalid[rclu_i];
      rtgt_o   = clu_rtgt[rclu_i];
    end
  end

  AST_ONE_CLUSTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clu_we)); // R8
endmodule

// File: rtl/rt_cache_match.sv
module rt_cache_match #(
  parameter int ADDR_W  = 32,
  parameter int NUM_PAT = 4,
  parameter int PAT_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_mask_i,
  input  logic              we_pat_i,
  input  logic [PAT_W-1:0]  slot_i,
  input  logic [ADDR_W:0]   data_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0]  mask_q;
  logic [ADDR_W-1:0]  pat_q [NUM_PAT];
  logic [NUM_PAT-1:0] en_q;
  logic [NUM_PAT-1:0] match;
  logic [ADDR_W-1:0]  masked;

  assign masked = addr_i & mask_q;

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[p]  <= 1'b0;
        pat_q[p] <= '0;
      end else if (we_pat_i && int'(slot_i) == p) begin
        en_q[p]  <= data_i[ADDR_W];
        pat_q[p] <= data_i[ADDR_W-1:0];
      end
    end
    assign match[p] = en_q[p] && (masked == pat_q[p]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (we_mask_i) mask_q <= data_i[ADDR_W-1:0];
  end

  assign hit_o = |match;

  AST_MASK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_mask_i |=> (mask_q == $past(data_i[ADDR_W-1:0]))); // R8
  AST_NO_HIT_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !hit_o); // R6
endmodule

// File: rtl/route_decoder.sv
module route_decoder
  import route_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int GLB_W        = 8,
  parameter int LOC_W        = 4,
  parameter int NUM_CLUSTERS = 4,
  parameter int CLU_W        = $clog2(NUM_CLUSTERS),
  parameter int TGT_W        = 4,
  parameter int NUM_PAT      = 4,
  parameter int SRC_W        = 10,
  parameter int SRC_GLB_W    = 8,
  parameter int CFG_IDX_W    = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  output logic                       cmd_valid_o,
  output logic [CLU_W-1:0]           cmd_cluster_o,
  output logic [TGT_W-1:0]           cmd_target_o,
  output logic                       cmd_err_o,
  output logic                       cmd_cache_o,
  input  logic                       rsp_valid_i,
  input  logic [SRC_W-1:0]           rsp_srcid_i,
  output logic                       rsp_valid_o,
  output logic [SRC_GLB_W-1:0]       rsp_cluster_o,
  output logic [SRC_W-SRC_GLB_W-1:0] rsp_initiator_o,
  output logic                       rsp_err_o,
  input  logic                       cfg_we_i,
  input  logic [1:0]                 cfg_sel_i,
  input  logic [CFG_IDX_W-1:0]       cfg_idx_i,
  input  logic [ADDR_W:0]            cfg_data_i
);
  localparam int PAT_W = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1;
  localparam int SRC_LOC_W = SRC_W - SRC_GLB_W;

  cfg_sel_e sel;
  assign sel = cfg_sel_e'(cfg_sel_i);

  logic [GLB_W-1:0] glb_idx;
  logic [LOC_W-1:0] loc_idx;
  logic             g_valid, l_valid, hit, cache_hit;
  logic [CLU_W-1:0] g_clu;
  logic [TGT_W-1:0] l_tgt;

  assign glb_idx = req_addr_i[ADDR_W-1 -: GLB_W];
  assign loc_idx = req_addr_i[ADDR_W-GLB_W-1 -: LOC_W];

  rt_global_table #(.IDX_W(GLB_W), .CLU_W(CLU_W)) u_glb (
    .clk_i, .rst_ni,
    .we_i     (cfg_we_i && sel == CFG_GLOBAL),
    .widx_i   (cfg_idx_i[GLB_W-1:0]),
    .wvalid_i (cfg_data_i[ADDR_W]),
    .wclu_i   (cfg_data_i[CLU_W-1:0]),
    .ridx_i   (glb_idx),
    .rvalid_o (g_valid),
    .rclu_o   (g_clu)
  );

  rt_local_tables #(.NUM_CLUSTERS(NUM_CLUSTERS), .CLU_W(CLU_W),
                    .LOC_W(LOC_W), .TGT_W(TGT_W)) u_loc (
    .clk_i, .rst_ni,
    .we_i     (cfg_we_i && sel == CFG_LOCAL),
    .wclu_i   (cfg_idx_i[LOC_W +: CLU_W]),
    .wloc_i   (cfg_idx_i[LOC_W-1:0]),
    .wvalid_i (cfg_data_i[ADDR_W]),
    .wtgt_i   (cfg_data_i[TGT_W-1:0]),
    .rclu_i   (g_clu),
    .rloc_i   (loc_idx),
    .rvalid_o (l_valid),
    .rtgt_o   (l_tgt)
  );

  rt_cache_match #(.ADDR_W(ADDR_W), .NUM_PAT(NUM_PAT), .PAT_W(PAT_W)) u_cache (
    .clk_i, .rst_ni,
    .we_mask_i (cfg_we_i && sel == CFG_MASK),
    .we_pat_i  (cfg_we_i && sel == CFG_PATTERN),
    .slot_i    (cfg_idx_i[PAT_W-1:0]),
    .data_i    (cfg_data_i),
    .addr_i    (req_addr_i),
    .hit_o     (cache_hit)
  );

  assign hit = g_valid && l_valid;

  logic [SRC_GLB_W-1:0] src_clu;
  logic                 src_bad;
  assign src_clu = rsp_srcid_i[SRC_W-1 -: SRC_GLB_W];
  assign src_bad = int'(src_clu) >= NUM_CLUSTERS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o     <= 1'b0;
      cmd_err_o       <= 1'b0;
      cmd_cache_o     <= 1'b0;
      cmd_cluster_o   <= '0;
      cmd_target_o    <= '0;
      rsp_valid_o     <= 1'b0;
      rsp_err_o       <= 1'b0;
      rsp_cluster_o   <= '0;
      rsp_initiator_o <= '0;
    end else begin
      cmd_valid_o     <= req_valid_i && hit;
      cmd_err_o       <= req_valid_i && !hit;
      cmd_cache_o     <= req_valid_i && cache_hit;
      cmd_cluster_o   <= (req_valid_i && hit) ? g_clu : '0;
      cmd_target_o    <= (req_valid_i && hit) ? l_tgt : '0;
      rsp_valid_o     <= rsp_valid_i;
      rsp_err_o       <= rsp_valid_i && src_bad;
      rsp_cluster_o   <= rsp_valid_i ? src_clu : '0;
      rsp_initiator_o <= rsp_valid_i ? rsp_srcid_i[SRC_LOC_W-1:0] : '0;
    end
  end

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_o && cmd_err_o)); // R4
  AST_REQ_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (cmd_valid_o || cmd_err_o)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !(cmd_valid_o || cmd_err_o || cmd_cache_o)); // R5
  AST_ERR_ZERO_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |-> (cmd_cluster_o == '0 && cmd_target_o == '0)); // R4
  AST_RSP_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |=> (rsp_valid_o && {rsp_cluster_o, rsp_initiator_o} == $past(rsp_srcid_i))); // R7
endmodule

// File: tb/route_decoder_bench.sv
module route_decoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        cmd_valid_o, cmd_err_o, cmd_cache_o;
  logic [1:0]  cmd_cluster_o;
  logic [3:0]  cmd_target_o;
  logic        rsp_valid_i = 1'b0;
  logic [9:0]  rsp_srcid_i = '0;
  logic        rsp_valid_o, rsp_err_o;
  logic [7:0]  rsp_cluster_o;
  logic [1:0]  rsp_initiator_o;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = '0;
  logic [7:0]  cfg_idx_i = '0;
  logic [32:0] cfg_data_i = '0;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk_i = ~clk_i;

  route_decoder u_route_decoder (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [7:0] idx, input logic [32:0] data);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_idx_i = idx; cfg_data_i = data;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // drive one request, sample the registered result one cycle later
  task automatic req(input logic [31:0] a);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic expect_hit(input string r, input logic [1:0] clu, input logic [3:0] tgt);
    chk({r, " valid"}, 32'(cmd_valid_o), 1);
    chk({r, " err"}, 32'(cmd_err_o), 0);
    chk({r, " cluster"}, 32'(cmd_cluster_o), 32'(clu));
    chk({r, " target"}, 32'(cmd_target_o), 32'(tgt));
  endtask

  task automatic expect_err(input string r);
    chk({r, " err"}, 32'(cmd_err_o), 1);
    chk({r, " valid"}, 32'(cmd_valid_o), 0);
    chk({r, " dest zero"}, 32'({cmd_cluster_o, cmd_target_o}), 0);
  endtask

  task automatic t_reset;
    chk("R1 cmd_valid", 32'(cmd_valid_o), 0);
    chk("R1 cmd_err", 32'(cmd_err_o), 0);
    chk("R1 cmd_cache", 32'(cmd_cache_o), 0);
    chk("R1 rsp_valid", 32'(rsp_valid_o), 0);
    chk("R1 rsp_err", 32'(rsp_err_o), 0);
    req(32'h1250_0000);
    expect_err("R1 empty tables");
    chk("R1 no cache", 32'(cmd_cache_o), 0);
  endtask

  task automatic t_program;
    cfg(2'd0, 8'h12, {1'b1, 32'd3});         // global 0x12 -> cluster 3
    cfg(2'd1, {2'd3, 4'h5}, {1'b1, 32'd2});  // cluster 3, local 5 -> target 2
    cfg(2'd0, 8'h40, {1'b1, 32'd1});         // global 0x40 -> cluster 1
    cfg(2'd1, {2'd1, 4'h5}, {1'b1, 32'd9});  // cluster 1, local 5 -> target 9
    req(32'h1255_0000);
    expect_hit("R2 R3 cluster3", 2'd3, 4'd2);
    req(32'h4050_0abc);
    expect_hit("R3 cluster1 own table", 2'd1, 4'd9);
  endtask

  task automatic t_errors;
    req(32'h12A0_0000);   // global valid, local invalid
    expect_err("R4 local invalid");
    req(32'h7750_0000);   // global invalid
    expect_err("R4 global invalid");
    @(negedge clk_i);     // one cycle later the error must be gone
    chk("R4 R5 err one cycle", 32'(cmd_err_o), 0);
    chk("R5 idle valid", 32'(cmd_valid_o), 0);
  endtask

  task automatic t_cache;
    cfg(2'd2, 8'd0, {1'b0, 32'h000C_0000});
    cfg(2'd3, 8'd0, {1'b1, 32'h0004_0000});
    cfg(2'd3, 8'd1, {1'b0, 32'h0008_0000});  // slot 1 disabled
    req(32'h1255_0000);
    chk("R6 pattern slot0 hit", 32'(cmd_cache_o), 1);
    req(32'h1258_0000);
    chk("R6 disabled slot miss", 32'(cmd_cache_o), 0);
    cfg(2'd3, 8'd1, {1'b1, 32'h0008_0000});
    req(32'h1258_0000);
    chk("R6 R8 enabled slot1 hit", 32'(cmd_cache_o), 1);
    req(32'h125C_0000);
    chk("R6 no pattern miss", 32'(cmd_cache_o), 0);
    @(negedge clk_i);
    chk("R5 cache idle", 32'(cmd_cache_o), 0);
  endtask

  task automatic t_collision;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = 32'h1255_0000;
    cfg_we_i = 1'b1; cfg_sel_i = 2'd0; cfg_idx_i = 8'h12; cfg_data_i = '0;
    @(negedge clk_i);
    req_valid_i = 1'b0; cfg_we_i = 1'b0;
    expect_hit("R9 old contents", 2'd3, 4'd2);
    req(32'h1255_0000);
    expect_err("R9 R8 new contents");
  endtask

  task automatic t_response;
    @(negedge clk_i);
    rsp_valid_i = 1'b1; rsp_srcid_i = {8'd2, 2'd1};
    @(negedge clk_i);
    rsp_srcid_i = {8'hC0, 2'd3};
    chk("R7 rsp valid", 32'(rsp_valid_o), 1);
    chk("R7 rsp cluster", 32'(rsp_cluster_o), 2);
    chk("R7 rsp initiator", 32'(rsp_initiator_o), 1);
    chk("R7 rsp no err", 32'(rsp_err_o), 0);
    @(negedge clk_i);
    rsp_valid_i = 1'b0;
    chk("R7 rsp cluster hi", 32'(rsp_cluster_o), 32'hC0);
    chk("R7 rsp initiator hi", 32'(rsp_initiator_o), 3);
    chk("R7 rsp out of range", 32'(rsp_err_o), 1);
    @(negedge clk_i);
    chk("R7 rsp idle", 32'({rsp_valid_o, rsp_err_o, rsp_cluster_o, rsp_initiator_o}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_program();
    t_errors();
    t_cache();
    t_collision();
    t_response();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule